// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between serial time-division streams. Sixteen input streams and eight output streams each carry 32 channels of 8 bits per frame, which gives 256 bit periods per frame. A frame marker input starts each frame. The block turns every input channel into a byte and stores it in a data memory. That memory has one bank for even frames and one for odd frames. For every output channel, a connect memory chooses what is sent:

- **Connection mode:** a byte from any input channel of the previous frame.
- **Message mode:** a fixed byte written by the CPU.

Because each output channel names its own source, one input channel can feed many output channels.

The CPU reaches the connect memory through a plain synchronous port. It has an address, write data, a write strobe and registered read data. Each connect entry has two parts:

- **Low byte:** the source channel in bits 4:0 and source-stream bits 2:0 in bits 7:5. In message mode this byte is the data sent.
- **High byte:** bit 0 is source-stream bit 3, bit 1 selects message mode, and bit 2 enables the output driver for that channel.

The CPU address is 9 bits. Bit 8 selects the high part (1) or the low part (0). Bits 7:5 give the output stream and bits 4:0 give the output channel. Each output stream has a drive-enable pin alongside its data pin. A global drive-enable input can force every stream off.

Timing: `frame_i` is high in the bit period that carries bit 7 (the MSB) of input channel 0. Input bits are sampled on the rising edge. Channel c occupies frame positions 8c to 8c+7, MSB first. The output bit for frame position q appears just after the rising edge that samples input position q, and is held for one period.

Top module: `tsi_switch`

## Requirements
- R1: After reset every `oe_o` bit is 0, and a read of any connect high part returns 0 until the CPU writes it.
- R2: In connection mode, output stream o, channel c of frame k carries, MSB first, the byte that arrived in frame k-1 on the input stream and channel named by its connect entry.
- R3: The delay is exactly one frame for every pairing, including input channel 31 routed to output channel 0, whose fetch coincides with that byte's arrival.
- R4: Any number of output channels may name the same input channel, and each receives that byte.
- R5: In message mode (high bit 1 = 1) the channel carries the connect low byte, unchanged in every frame.
- R6: With high bit 2 = 0, `oe_o` of that stream is 0 for all 8 bit periods of the channel.
- R7: While `drv_en_i` is 0, every `oe_o` bit is 0, regardless of the connect entries.
- R8: A CPU read returns, one cycle after the address is presented, the last value written to that location. High-part reads return the 3 stored bits zero-extended.
- R9: A CPU write issued in the same cycle as an output fetch is stored, and it reads back correctly.
- R10: A `frame_i` pulse at any point restarts the frame at position 0, and later frames align to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| frame_i | input | 1 | Frame start marker, high during the first bit period |
| ser_i | input | 16 | Serial input streams |
| drv_en_i | input | 1 | Global output drive enable |
| cpu_addr_i | input | 9 | Connect memory address: {high select, stream, channel} |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_rdata_o | output | 8 | Registered CPU read data |
| ser_o | output | 8 | Serial output streams |
| oe_o | output | 8 | Per-stream drive enable for the current bit |

## Verification
The hardest case to reach is the frame wrap. There, the fetch for output channel 0 must read input channel 31 of the frame that is ending, in the very cycle that byte is being stored. The routing configuration places a channel-31 source behind channel 0 on several streams, so that forwarding path is exercised every frame. A CPU write is aimed at a fetch cycle by stepping the bench's own bit-position counter to the last bit of a slot. Frame resynchronisation is reached by issuing a frame pulse at position 100 of a running frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    // Positions of the control bits above the stream extension in a high entry
    localparam int HI_MSG_OFS   = 0;
    localparam int HI_DRIVE_OFS = 1;
    localparam int HI_CTL_BITS  = 2;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
    parameter int FRAME_BITS = 256,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_ni,
    input  logic          frame_i,
    output logic [PW-1:0] pos_o,
    output logic          par_o
);
    typedef struct packed {
        logic [PW-1:0] pos;
        logic          par;
    } tm_t;

    tm_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (frame_i || st_q.pos == PW'(FRAME_BITS - 1)) begin
            st_d.pos = '0;
            st_d.par = ~st_q.par;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_ni) st_q <= '{pos: PW'(FRAME_BITS - 1), par: 1'b0};
        else         st_q <= st_d;
    end

    // Position of the bit sampled at the coming edge
    assign pos_o = st_d.pos;
    assign par_o = st_d.par;

    assert_resync_R10: assert property (@(posedge clk) disable iff (!rst_ni)
        frame_i |=> (st_q.pos == '0) && (st_q.par != $past(st_q.par)));
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
    parameter int N_IN  = 16,
    parameter int CHANS = 32,
    parameter int W     = 8,
    parameter int N_RD  = 8,
    localparam int SIW   = $clog2(N_IN),
    localparam int CHW   = $clog2(CHANS),
    localparam int AW    = 1 + CHW + SIW,
    localparam int DEPTH = 1 << AW
) (
    input  logic                      clk,
    input  logic [N_IN-1:0]           ser_i,
    input  logic                      wr_en_i,
    input  logic                      wr_bank_i,
    input  logic [CHW-1:0]            wr_ch_i,
    input  logic [N_RD-1:0][AW-1:0]   rd_addr_i,
    output logic [N_RD-1:0][W-1:0]    rd_data_o
);
    logic [N_IN-1:0][W-1:0] sh_q, sh_d;
    logic [W-1:0]           mem [DEPTH];

    always_comb begin
        for (int s = 0; s < N_IN; s++) sh_d[s] = {sh_q[s][W-2:0], ser_i[s]};
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
        if (wr_en_i) begin
            for (int s = 0; s < N_IN; s++) mem[{wr_bank_i, wr_ch_i, SIW'(s)}] <= sh_d[s];
        end
    end

    // Reads see a byte completing in this same cycle through a bypass
    always_comb begin
        for (int r = 0; r < N_RD; r++) begin
            if (wr_en_i && rd_addr_i[r][AW-1:SIW] == {wr_bank_i, wr_ch_i})
                rd_data_o[r] = sh_d[rd_addr_i[r][SIW-1:0]];
            else
                rd_data_o[r] = mem[rd_addr_i[r]];
        end
    end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
    parameter int N_OUT = 8,
    parameter int CHANS = 32,
    parameter int N_IN  = 16,
    parameter int W     = 8,
    localparam int OSW = $clog2(N_OUT),
    localparam int CHW = $clog2(CHANS),
    localparam int SIW = $clog2(N_IN),
    localparam int XB  = SIW + CHW - W,
    localparam int HIW = XB + tsi_pkg::HI_CTL_BITS,
    localparam int EW  = OSW + CHW,
    localparam int AW  = EW + 1,
    localparam int ENT = 1 << EW
) (
    input  logic                      clk,
    input  logic                      rst_ni,
    input  logic [AW-1:0]             cpu_addr_i,
    input  logic [W-1:0]              cpu_wdata_i,
    input  logic                      cpu_we_i,
    output logic [W-1:0]              cpu_rdata_o,
    input  logic [CHW-1:0]            fch_ch_i,
    output logic [N_OUT-1:0][W-1:0]   lo_o,
    output logic [N_OUT-1:0][HIW-1:0] hi_o
);
    logic [W-1:0]   lo_q [ENT];
    logic [HIW-1:0] hi_q [ENT];
    logic [W-1:0]   rd_d, rd_q;
    logic [EW-1:0]  idx;
    logic           sel_hi;

    assign idx    = cpu_addr_i[EW-1:0];
    assign sel_hi = cpu_addr_i[AW-1];

    always_comb begin
        rd_d = sel_hi ? W'(hi_q[idx]) : lo_q[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            rd_q <= '0;
            for (int e = 0; e < ENT; e++) hi_q[e] <= '0;
        end else begin
            rd_q <= rd_d;
            if (cpu_we_i && sel_hi) hi_q[idx] <= cpu_wdata_i[HIW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (cpu_we_i && !sel_hi) lo_q[idx] <= cpu_wdata_i;
    end

    assign cpu_rdata_o = rd_q;

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            lo_o[o] = lo_q[{OSW'(o), fch_ch_i}];
            hi_o[o] = hi_q[{OSW'(o), fch_ch_i}];
        end
    end

    assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_ni)
        (cpu_we_i && !sel_hi) ##1 (!cpu_we_i && $stable(cpu_addr_i))
        |=> cpu_rdata_o == $past(cpu_wdata_i, 2));
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
    parameter int N_OUT = 8,
    parameter int W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_ni,
    input  logic                    load_i,
    input  logic [N_OUT-1:0][W-1:0] byte_i,
    input  logic [N_OUT-1:0]        en_i,
    input  logic                    drv_en_i,
    output logic [N_OUT-1:0]        ser_o,
    output logic [N_OUT-1:0]        oe_o
);
    typedef struct packed {
        logic [N_OUT-1:0][W-1:0] sr;
        logic [N_OUT-1:0]        en;
    } tx_t;

    tx_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sr = byte_i;
            st_d.en = en_i;
        end else begin
            for (int o = 0; o < N_OUT; o++) st_d.sr[o] = {st_q.sr[o][W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) ser_o[o] = st_q.sr[o][W-1];
    end
    assign oe_o = st_q.en & {N_OUT{drv_en_i}};

    // Channel drive state only changes at a slot boundary
    assert_slot_enable_R6: assert property (@(posedge clk) disable iff (!rst_ni)
        !load_i |=> $stable(st_q.en));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int CHANS = 32,
    parameter int W     = 8,
    localparam int FB  = CHANS * W,
    localparam int PW  = $clog2(FB),
    localparam int BW  = $clog2(W),
    localparam int CHW = $clog2(CHANS),
    localparam int SIW = $clog2(N_IN),
    localparam int OSW = $clog2(N_OUT),
    localparam int XB  = SIW + CHW - W,
    localparam int HIW = XB + tsi_pkg::HI_CTL_BITS,
    localparam int DAW = 1 + CHW + SIW,
    localparam int CAW = OSW + CHW + 1
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             frame_i,
    input  logic [N_IN-1:0]  ser_i,
    input  logic             drv_en_i,
    input  logic [CAW-1:0]   cpu_addr_i,
    input  logic [W-1:0]     cpu_wdata_i,
    input  logic             cpu_we_i,
    output logic [W-1:0]     cpu_rdata_o,
    output logic [N_OUT-1:0] ser_o,
    output logic [N_OUT-1:0] oe_o
);
    typedef struct packed {
        logic [N_OUT-1:0][W-1:0] fbyte;
        logic [N_OUT-1:0]        fen;
    } fe_t;

    logic [PW-1:0]              pos;
    logic                       par;
    logic [CHW-1:0]             slot, tgt;
    logic                       fetch_now, load_now, rd_bank;
    logic [N_OUT-1:0][W-1:0]    cm_lo, rd_data;
    logic [N_OUT-1:0][HIW-1:0]  cm_hi;
    logic [N_OUT-1:0][DAW-1:0]  rd_addr;
    fe_t                        fe_q, fe_d;

    tsi_timing #(.FRAME_BITS(FB)) u_timing (
        .clk(clk), .rst_ni(rst_ni), .frame_i(frame_i), .pos_o(pos), .par_o(par)
    );

    assign slot      = pos[PW-1:BW];
    assign tgt       = slot + 1'b1;
    assign fetch_now = pos[BW-1:0] == BW'(W - 1);
    assign load_now  = pos[BW-1:0] == '0;
    // Slot 0 of the next frame reads the frame now ending; others read the previous one
    assign rd_bank   = (tgt == '0) ? par : ~par;

    tsi_rx #(.N_IN(N_IN), .CHANS(CHANS), .W(W), .N_RD(N_OUT)) u_rx (
        .clk(clk), .ser_i(ser_i), .wr_en_i(fetch_now), .wr_bank_i(par),
        .wr_ch_i(slot), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    tsi_cmem #(.N_OUT(N_OUT), .CHANS(CHANS), .N_IN(N_IN), .W(W)) u_cmem (
        .clk(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_we_i(cpu_we_i), .cpu_rdata_o(cpu_rdata_o), .fch_ch_i(tgt),
        .lo_o(cm_lo), .hi_o(cm_hi)
    );

    always_comb begin
        for (int o = 0; o < N_OUT; o++)
            rd_addr[o] = {rd_bank, cm_lo[o][CHW-1:0], cm_hi[o][XB-1:0], cm_lo[o][W-1:CHW]};
    end

    always_comb begin
        fe_d = fe_q;
        if (fetch_now) begin
            for (int o = 0; o < N_OUT; o++) begin
                fe_d.fbyte[o] = cm_hi[o][XB + tsi_pkg::HI_MSG_OFS] ? cm_lo[o] : rd_data[o];
                fe_d.fen[o]   = cm_hi[o][XB + tsi_pkg::HI_DRIVE_OFS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_ni) fe_q <= '0;
        else         fe_q <= fe_d;
    end

    tsi_tx #(.N_OUT(N_OUT), .W(W)) u_tx (
        .clk(clk), .rst_ni(rst_ni), .load_i(load_now), .byte_i(fe_q.fbyte),
        .en_i(fe_q.fen), .drv_en_i(drv_en_i), .ser_o(ser_o), .oe_o(oe_o)
    );

    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        !fetch_now |=> $stable(fe_q));

    assert_global_off_R7: assert property (@(posedge clk) disable iff (!rst_ni)
        !drv_en_i |-> oe_o == '0);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(rst_ni) |-> oe_o == '0);
endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    localparam int NI = 16, NO = 8, CH = 32;

    logic          clk = 1'b0;
    logic          rst_n, frame, drv_en, cwe;
    logic [NI-1:0] sin;
    logic [8:0]    caddr;
    logic [7:0]    cwd, crd;
    logic [NO-1:0] sout, oe;

    always #2 clk = ~clk;

    tsi_switch u_tsi_switch (
        .clk(clk), .rst_ni(rst_n), .frame_i(frame), .ser_i(sin), .drv_en_i(drv_en),
        .cpu_addr_i(caddr), .cpu_wdata_i(cwd), .cpu_we_i(cwe), .cpu_rdata_o(crd),
        .ser_o(sout), .oe_o(oe)
    );

    int total = 0, bad = 0, bq = 0, fnum = 0, check_from = 1 << 30;
    string conn_tag = "R2";
    logic [7:0] m_lo [256];
    logic [2:0] m_hi [256];

    function automatic logic [7:0] in_byte(int f, int s, int c);
        return 8'(f * 37 + s * 11 + c * 5 + 3);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_out();
        int c, b, e;
        logic [7:0] lo, eb;
        logic [2:0] hi;
        logic eoe;
        string tag;
        c = bq / 8;
        b = 7 - bq % 8;
        for (int o = 0; o < NO; o++) begin
            e = o * CH + c;
            lo = m_lo[e];
            hi = m_hi[e];
            eoe = drv_en & hi[2];
            if (!drv_en) tag = "R7";
            else if (!hi[2]) tag = "R6";
            else if (hi[1]) tag = "R5";
            else if (c == 0 && lo[4:0] == 5'd31) tag = "R3";
            else tag = conn_tag;
            chk(oe[o] == eoe, tag, $sformatf("drive s%0d ch%0d", o, c), oe[o], eoe);
            if (eoe) begin
                eb = hi[1] ? lo : in_byte(fnum - 1, {hi[0], lo[7:5]}, lo[4:0]);
                chk(sout[o] == eb[b], tag, $sformatf("data s%0d ch%0d b%0d", o, c, b), sout[o], eb[b]);
            end
        end
    endtask

    task automatic step(bit we, logic [8:0] a, logic [7:0] d);
        logic [7:0] ib;
        frame = (bq == 0);
        for (int s = 0; s < NI; s++) begin
            ib = in_byte(fnum, s, bq / 8);
            sin[s] = ib[7 - bq % 8];
        end
        cwe = we;
        caddr = a;
        cwd = d;
        @(posedge clk);
        @(negedge clk);
        if (fnum >= check_from) check_out();
        bq++;
        if (bq == 256) begin
            bq = 0;
            fnum++;
        end
    endtask

    task automatic run_frames(int n);
        int stop;
        stop = fnum + n;
        while (fnum < stop) step(1'b0, 9'd0, 8'd0);
    endtask

    task automatic load_cfg(int kind);
        logic [3:0] ss;
        logic [4:0] sc;
        logic [7:0] lo;
        logic [2:0] hi;
        check_from = 1 << 30;
        for (int e = 0; e < 256; e++) begin
            int o, c;
            o = e / CH;
            c = e % CH;
            if (kind == 0) begin
                ss = 4'((o * 3 + c) % 16);
                sc = (c == 0) ? 5'd31 : 5'((c * 7 + o + 1) % 32);
                hi = {2'b10, ss[3]};
                lo = {ss[2:0], sc};
            end else begin
                ss = 4'((o * 5 + c + 2) % 16);
                sc = 5'((c * 5 + o) % 32);
                if (o == 2 || (o == 5 && c % 2 == 0)) begin
                    ss = 4'd13;
                    sc = 5'd9;
                end
                hi = {2'b10, ss[3]};
                lo = {ss[2:0], sc};
                if (o == 4 && c % 2 == 1) begin
                    hi = 3'b110;
                    lo = 8'(c * 9 + 90);
                end
                if (o == 6 && c % 3 == 0) hi = 3'b000;
            end
            m_lo[e] = lo;
            m_hi[e] = hi;
            step(1'b1, {1'b0, 8'(e)}, lo);
            step(1'b1, {1'b1, 8'(e)}, {5'd0, hi});
        end
        check_from = fnum + 2;
    endtask

    initial begin
        rst_n = 1'b0; frame = 1'b0; sin = '0; drv_en = 1'b1;
        caddr = '0; cwd = '0; cwe = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 9'h100 | 9'(i * 37), 8'd0);
            chk(crd == 8'd0, "R1", "high part after reset", crd, 0);
            chk(oe == '0, "R1", "drive after reset", oe, 0);
        end

        load_cfg(0);
        conn_tag = "R2";
        run_frames(4);

        // R8: readback of both parts, high part zero-extended
        check_from = 1 << 30;
        step(1'b1, {1'b0, 8'd37}, 8'hC3);
        step(1'b0, {1'b0, 8'd37}, 8'd0);
        chk(crd == 8'hC3, "R8", "low readback", crd, 8'hC3);
        step(1'b1, {1'b1, 8'd37}, 8'hFD);
        step(1'b0, {1'b1, 8'd37}, 8'd0);
        chk(crd == 8'h05, "R8", "high readback", crd, 8'h05);
        step(1'b1, {1'b0, 8'd37}, m_lo[37]);
        step(1'b1, {1'b1, 8'd37}, {5'd0, m_hi[37]});

        // R9: write landing exactly on a fetch cycle
        while (bq % 8 != 7) step(1'b0, 9'd0, 8'd0);
        step(1'b1, {1'b0, 8'd70}, 8'h3C);
        step(1'b0, {1'b0, 8'd70}, 8'd0);
        chk(crd == 8'h3C, "R9", "write during fetch", crd, 8'h3C);
        step(1'b1, {1'b0, 8'd70}, m_lo[70]);
        check_from = fnum + 2;
        run_frames(3);

        load_cfg(1);
        conn_tag = "R4";
        run_frames(4);

        // R7: global drive enable low for a whole frame
        while (bq != 0) step(1'b0, 9'd0, 8'd0);
        drv_en = 1'b0;
        repeat (256) step(1'b0, 9'd0, 8'd0);
        drv_en = 1'b1;
        run_frames(1);

        // R10: early frame pulse in mid-frame
        while (bq != 100) step(1'b0, 9'd0, 8'd0);
        bq = 0;
        fnum++;
        check_from = fnum + 2;
        conn_tag = "R10";
        run_frames(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", fnum, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule